// File: doc/BRIEF.md
# Stuck-At Cell Write Controller with Partition Inversion

This block writes data words into a memory array whose cells can be permanently stuck at 0 or 1. The 64-bit word is divided into eight 8-bit partitions. Each partition is stored either unchanged or bit-inverted, and one inversion flag per partition is stored next to the data. Each write is followed by a read-back. A partition whose read-back differs from what was written has its flag toggled, and the word is written a second time. A single stuck cell then ends up holding the value it is stuck at. If a partition still differs after the second write, it is reported as uncorrectable.

A four-entry cache remembers recently found faulty bits: the address, the bit position and the stuck value. When a new write hits the cache, the controller sets the matching partition's flag before the first write, and no second write is needed. While the controller is idle, a read port passes an address to the array and returns the word with the stored inversions removed.

Top module: `sa_inv_writer`

## Requirements
- R1: After reset, `wr_ready_o` is 1 and `mem_we_o`, `done_o`, `fail_o` and `fail_mask_o` are all 0.
- R2: Every word driven on `mem_wdata_o` has the following layout. Bit 64+p is the flag of partition p. Bits 8p+7..8p are the request data bits 8p+7..8p, XORed with that flag.
- R3: Write sequence:
  - A request is written once and then read back.
  - If the read-back matches, `done_o` follows with `fail_mask_o` = 0 and no second write.
  - With no fault and no cache hit, all flags are 0.
- R4: Second write:
  - Any partition whose read-back (data or flag) differs from the written word has its flag toggled.
  - The whole word is then written once more and read back again.
  - There are never more than two writes per request.
- R5: If every partition holds at most one stuck cell, the word read back through the read port equals the requested data after the request completes.
- R6: Uncorrectable partitions:
  - A partition that still differs after the second write sets its bit in `fail_mask_o`.
  - `fail_o` is high only in the `done_o` cycle, and only when that mask is nonzero.
- R7: Cache fill:
  - After a first read-back with a data mismatch, the lowest mismatching data bit is stored in the cache.
  - The entry holds the address, the bit position and the value read back.
- R8: Cache hit:
  - A request whose address matches a cache entry presets that bit's partition flag to (data bit XOR stuck value).
  - If that bit is the only fault, the request completes with a single write.
- R9: While `wr_ready_o` is 1, `mem_addr_o` equals `rd_addr_i`. `rd_data_o` is the data part of `mem_rdata_i`, with each partition XORed with its stored flag.
- R10: Handshake:
  - A request is taken only when `wr_valid_i` and `wr_ready_o` are both high.
  - `wr_ready_o` stays low until the cycle after the single-cycle `done_o` pulse.
  - `mem_addr_o` holds steady while the controller is busy.
- R11: The cache has 4 entries and replaces them in round-robin order. After four more faults are learned, the oldest entry is forgotten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Write request valid |
| wr_ready_o | output | 1 | Controller idle, request can be taken |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 64 | Write data |
| done_o | output | 1 | One-cycle pulse: request finished |
| fail_o | output | 1 | Uncorrectable partition in finished request |
| fail_mask_o | output | 8 | Partitions left uncorrectable |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | 4 | Array address |
| mem_wdata_o | output | 72 | Stored word: flags and encoded data |
| mem_rdata_i | input | 72 | Array read-back at `mem_addr_o` |
| rd_addr_i | input | 4 | Read port address |
| rd_data_o | output | 64 | Decoded read data |

## Verification
The hardest cases to reach from the ports are those that depend on cache history: a preset flag that removes the second write, and round-robin eviction that brings the second write back. Directed sequences cover these. Faults are placed at chosen addresses in the bench's array model, and the number of faults learned is controlled so that a specific entry is evicted. A partition with two stuck cells of opposite needs drives the uncorrectable path. Seeded random writes over single-fault addresses then check the decoded read data and the write count.

// File: rtl/sa_wr_pkg.sv
package sa_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_VERIFY,
    ST_REWRITE,
    ST_VERIFY2,
    ST_DONE
  } wr_state_e;
endpackage

// File: rtl/sa_part_xor.sv
module sa_part_xor #(
  parameter int DATA_W = 64,
  parameter int PART_W = 8,
  localparam int NPART = DATA_W / PART_W
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [NPART-1:0]  inv_i,
  output logic [DATA_W-1:0] data_o
);
  for (genvar p = 0; p < NPART; p++) begin : g_part
    assign data_o[p*PART_W +: PART_W] = data_i[p*PART_W +: PART_W] ^ {PART_W{inv_i[p]}};
  end
endmodule

// File: rtl/sa_mismatch.sv
module sa_mismatch #(
  parameter int DATA_W = 64,
  parameter int PART_W = 8,
  localparam int NPART = DATA_W / PART_W,
  localparam int WORD_W = DATA_W + NPART,
  localparam int POS_W = $clog2(DATA_W)
) (
  input  logic [WORD_W-1:0] exp_i,
  input  logic [WORD_W-1:0] got_i,
  output logic [NPART-1:0]  part_mask_o,
  output logic              first_hit_o,
  output logic [POS_W-1:0]  first_pos_o,
  output logic              first_val_o
);
  logic [WORD_W-1:0] diff;
  assign diff = exp_i ^ got_i;

  for (genvar p = 0; p < NPART; p++) begin : g_part
    assign part_mask_o[p] = (|diff[p*PART_W +: PART_W]) | diff[DATA_W+p];
  end

  // lowest mismatching data bit
  always_comb begin
    first_hit_o = 1'b0;
    first_pos_o = '0;
    first_val_o = 1'b0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (diff[i]) begin
        first_hit_o = 1'b1;
        first_pos_o = POS_W'(i);
        first_val_o = got_i[i];
      end
    end
  end
endmodule

// File: rtl/sa_fault_cache.sv
module sa_fault_cache #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 64,
  parameter int PART_W  = 8,
  parameter int CACHE_N = 4,
  localparam int NPART = DATA_W / PART_W,
  localparam int POS_W = $clog2(DATA_W),
  localparam int PIDX_W = (NPART > 1) ? $clog2(NPART) : 1,
  localparam int PSH = $clog2(PART_W),
  localparam int PTR_W = (CACHE_N > 1) ? $clog2(CACHE_N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_addr_i,
  input  logic [DATA_W-1:0] lk_data_i,
  output logic [NPART-1:0]  lk_inv_o,
  input  logic              ins_i,
  input  logic [ADDR_W-1:0] ins_addr_i,
  input  logic [POS_W-1:0]  ins_pos_i,
  input  logic              ins_val_i
);
  logic [CACHE_N-1:0] vld_q;
  logic [ADDR_W-1:0]  addr_q [CACHE_N];
  logic [POS_W-1:0]   pos_q  [CACHE_N];
  logic [CACHE_N-1:0] val_q;
  logic [PTR_W-1:0]   ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      val_q <= '0;
      ptr_q <= '0;
      for (int e = 0; e < CACHE_N; e++) begin
        addr_q[e] <= '0;
        pos_q[e]  <= '0;
      end
    end else if (ins_i) begin
      vld_q[ptr_q]  <= 1'b1;
      addr_q[ptr_q] <= ins_addr_i;
      pos_q[ptr_q]  <= ins_pos_i;
      val_q[ptr_q]  <= ins_val_i;
      ptr_q <= (ptr_q == PTR_W'(CACHE_N - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_comb begin
    lk_inv_o = '0;
    for (int e = 0; e < CACHE_N; e++) begin
      if (vld_q[e] && addr_q[e] == lk_addr_i)
        lk_inv_o[PIDX_W'(pos_q[e] >> PSH)] = lk_inv_o[PIDX_W'(pos_q[e] >> PSH)]
                                             | (lk_data_i[pos_q[e]] ^ val_q[e]);
    end
  end
endmodule

// File: rtl/sa_inv_writer.sv
module sa_inv_writer
  import sa_wr_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int PART_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int CACHE_N = 4,
  localparam int NPART = DATA_W / PART_W,
  localparam int WORD_W = DATA_W + NPART,
  localparam int POS_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              done_o,
  output logic              fail_o,
  output logic [NPART-1:0]  fail_mask_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  wr_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [NPART-1:0]  inv_q;
  logic [NPART-1:0]  fail_q;

  logic [NPART-1:0]  lk_inv;
  logic [DATA_W-1:0] enc_data;
  logic [NPART-1:0]  mm_mask;
  logic              mm_hit;
  logic [POS_W-1:0]  mm_pos;
  logic              mm_val;
  logic              learn;

  sa_part_xor #(.DATA_W(DATA_W), .PART_W(PART_W)) u_enc (
    .data_i(data_q), .inv_i(inv_q), .data_o(enc_data)
  );

  sa_part_xor #(.DATA_W(DATA_W), .PART_W(PART_W)) u_dec (
    .data_i(mem_rdata_i[DATA_W-1:0]), .inv_i(mem_rdata_i[WORD_W-1:DATA_W]), .data_o(rd_data_o)
  );

  sa_mismatch #(.DATA_W(DATA_W), .PART_W(PART_W)) u_cmp (
    .exp_i(mem_wdata_o), .got_i(mem_rdata_i), .part_mask_o(mm_mask),
    .first_hit_o(mm_hit), .first_pos_o(mm_pos), .first_val_o(mm_val)
  );

  assign learn = (state_q == ST_VERIFY) && (|mm_mask) && mm_hit;

  sa_fault_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PART_W(PART_W), .CACHE_N(CACHE_N)) u_cache (
    .clk_i, .rst_ni,
    .lk_addr_i(wr_addr_i), .lk_data_i(wr_data_i), .lk_inv_o(lk_inv),
    .ins_i(learn), .ins_addr_i(addr_q), .ins_pos_i(mm_pos), .ins_val_i(mm_val)
  );

  assign wr_ready_o  = (state_q == ST_IDLE);
  assign mem_we_o    = (state_q == ST_WRITE) || (state_q == ST_REWRITE);
  assign mem_addr_o  = wr_ready_o ? rd_addr_i : addr_q;
  assign mem_wdata_o = {inv_q, enc_data};
  assign done_o      = (state_q == ST_DONE);
  assign fail_o      = done_o && (|fail_q);
  assign fail_mask_o = fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      inv_q   <= '0;
      fail_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (wr_valid_i) begin
          addr_q  <= wr_addr_i;
          data_q  <= wr_data_i;
          inv_q   <= lk_inv;
          fail_q  <= '0;
          state_q <= ST_WRITE;
        end
        ST_WRITE:   state_q <= ST_VERIFY;
        ST_VERIFY: begin
          if (|mm_mask) begin
            inv_q   <= inv_q ^ mm_mask;
            state_q <= ST_REWRITE;
          end else begin
            state_q <= ST_DONE;
          end
        end
        ST_REWRITE: state_q <= ST_VERIFY2;
        ST_VERIFY2: begin
          fail_q  <= mm_mask;
          state_q <= ST_DONE;
        end
        ST_DONE:    state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sa_inv_writer_chk.sv
module sa_inv_writer_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic              wr_ready_o,
  input logic              done_o,
  input logic              fail_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  logic [1:0] wr_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         wr_cnt_q <= '0;
    else if (wr_ready_o) wr_cnt_q <= '0;
    else if (mem_we_o)   wr_cnt_q <= wr_cnt_q + 1'b1;
  end

  a_r1_idle_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ready_o |-> !mem_we_o);

  a_r4_write_then_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  a_r4_max_two_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> wr_cnt_q < 2'd2);

  a_r6_fail_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o);

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && wr_ready_o));

  a_r10_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ready_o && wr_valid_i) |=> !wr_ready_o);

  a_r10_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ready_o && !$past(wr_ready_o)) |-> $stable(mem_addr_o));
endmodule

bind sa_inv_writer sa_inv_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
  .done_o(done_o), .fail_o(fail_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o)
);

// File: tb/sa_inv_writer_tb_top.sv
module sa_inv_writer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [3:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic        done, fail;
  logic [7:0]  fail_mask;
  logic        mem_we;
  logic [3:0]  mem_addr;
  logic [71:0] mem_wdata, mem_rdata;
  logic [3:0]  rd_addr = '0;
  logic [63:0] rd_data;

  logic [71:0] arr  [16];
  logic [71:0] sa_m [16];
  logic [71:0] sa_v [16];

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sa_inv_writer dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .done_o(done), .fail_o(fail), .fail_mask_o(fail_mask),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  // array model with stuck cells
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) arr[i] <= '0;
    end else if (mem_we) begin
      arr[mem_addr] <= mem_wdata;
    end
  end
  assign mem_rdata = (arr[mem_addr] & ~sa_m[mem_addr]) | (sa_m[mem_addr] & sa_v[mem_addr]);

  task automatic check(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_fail(input int a, input logic [63:0] d);
    logic [7:0] r;
    r = '0;
    for (int p = 0; p < 8; p++) begin
      bit ok0 = 1, ok1 = 1;
      for (int i = 0; i < 8; i++) begin
        int b = p*8 + i;
        if (sa_m[a][b]) begin
          if (sa_v[a][b] != d[b])  ok0 = 0;
          if (sa_v[a][b] == d[b])  ok1 = 0;
        end
      end
      if (sa_m[a][64+p]) begin
        if (sa_v[a][64+p] != 1'b0) ok0 = 0;
        if (sa_v[a][64+p] != 1'b1) ok1 = 0;
      end
      r[p] = !(ok0 || ok1);
    end
    return r;
  endfunction

  function automatic bit plain_ok(input int a, input logic [63:0] d);
    return ((d ^ sa_v[a][63:0]) & sa_m[a][63:0]) == 64'd0 && sa_m[a][71:64] == 8'd0;
  endfunction

  function automatic logic [63:0] expand(input logic [7:0] f);
    logic [63:0] r;
    for (int p = 0; p < 8; p++) r[p*8 +: 8] = {8{f[p]}};
    return r;
  endfunction

  int         nwr;
  logic [7:0] got_fm;
  logic       got_fl;
  logic [7:0] last_flags;

  task automatic do_write(input logic [3:0] a, input logic [63:0] d);
    bit seen = 0;
    nwr = 0;
    last_flags = '0;
    @(negedge clk);
    check(wr_ready, "R10 ready before request", {71'd0, wr_ready}, 72'd1);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    check(!wr_ready, "R10 busy after accept", {71'd0, wr_ready}, 72'd0);
    for (int k = 0; k < 20; k++) begin
      if (mem_we) begin
        nwr++;
        last_flags = mem_wdata[71:64];
        check(mem_wdata[63:0] == (d ^ expand(mem_wdata[71:64])), "R2 stored encoding",
              mem_wdata, {mem_wdata[71:64], d ^ expand(mem_wdata[71:64])});
        check(mem_addr == a, "R10 write address", {68'd0, mem_addr}, {68'd0, a});
      end
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    check(seen, "R10 done reached", {71'd0, seen}, 72'd1);
    got_fm = fail_mask;
    got_fl = fail;
    check(got_fl == (got_fm != 0), "R6 fail flag vs mask", {71'd0, got_fl}, {71'd0, got_fm != 0});
    @(negedge clk);
    check(!done && wr_ready, "R10 single done pulse", {70'd0, done, wr_ready}, 72'd1);
  endtask

  task automatic rd_check(input logic [3:0] a, input logic [63:0] d, input logic [7:0] fm);
    logic [63:0] keep;
    keep = ~expand(fm);
    rd_addr = a;
    #1;
    check(mem_addr == a, "R9 read address", {68'd0, mem_addr}, {68'd0, a});
    check((rd_data & keep) == (d & keep), "R5 R9 decoded read", {8'd0, rd_data & keep}, {8'd0, d & keep});
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    errors++; checks++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] d;
    void'($urandom(32'd4711));
    for (int a = 0; a < 16; a++) begin sa_m[a] = '0; sa_v[a] = '0; end
    // addr 0..3: one stuck-at-1 each, distinct partitions
    for (int a = 0; a < 4; a++) begin sa_m[a][a*8+3] = 1'b1; sa_v[a][a*8+3] = 1'b1; end
    // addr 4..11: random single fault per partition
    for (int a = 4; a < 12; a++)
      for (int p = 0; p < 8; p++)
        if ($urandom_range(0, 1) == 1) begin
          int b = p*8 + $urandom_range(0, 7);
          sa_m[a][b] = 1'b1;
          sa_v[a][b] = 1'($urandom_range(0, 1));
        end
    // addr 12: two opposite-need faults in partition 3
    sa_m[12][24] = 1'b1; sa_v[12][24] = 1'b0;
    sa_m[12][25] = 1'b1; sa_v[12][25] = 1'b1;
    // addr 14: bit 10 stuck at 1
    sa_m[14][10] = 1'b1; sa_v[14][10] = 1'b1;

    #(CLK_PERIOD*2 + 2);
    check(wr_ready && !mem_we && !done && !fail && fail_mask == 0, "R1 reset state",
          {67'd0, wr_ready, mem_we, done, fail, |fail_mask}, 72'h10);
    rst_n = 1'b1;
    @(negedge clk);
    check(wr_ready && !mem_we && !done && fail_mask == 0, "R1 after release",
          {68'd0, wr_ready, mem_we, done, |fail_mask}, 72'h8);

    // R3: clean address
    do_write(4'd13, 64'hA5A5_0F0F_1234_5678);
    check(nwr == 1 && last_flags == 0 && got_fm == 0, "R3 clean write",
          {32'd0, 8'(nwr), last_flags, got_fm, 16'd0}, {32'd0, 8'd1, 8'd0, 8'd0, 16'd0});
    rd_check(4'd13, 64'hA5A5_0F0F_1234_5678, 8'd0);

    // R4/R5: stuck at 1 on bit 10, data bit 10 = 0
    do_write(4'd14, 64'h0000_0000_0000_0000);
    check(nwr == 2 && last_flags == 8'h02 && got_fm == 0, "R4 rewrite with flag toggled",
          {48'd0, 8'(nwr), last_flags, got_fm}, {48'd0, 8'd2, 8'h02, 8'h00});
    rd_check(4'd14, 64'd0, 8'd0);

    // R7/R8: cache hit presets flag
    do_write(4'd14, 64'hFFFF_0000_1234_F8FF);
    check(nwr == 1 && last_flags == 8'h02, "R8 cache hit single write",
          {56'd0, 8'(nwr), last_flags}, {56'd0, 8'd1, 8'h02});
    rd_check(4'd14, 64'hFFFF_0000_1234_F8FF, 8'd0);
    do_write(4'd14, 64'h0000_0000_0000_0400);
    check(nwr == 1 && last_flags == 8'h00, "R7 R8 hit with matching bit",
          {56'd0, 8'(nwr), last_flags}, {56'd0, 8'd1, 8'h00});

    // R11: learn four more faults, evicting addr 14
    for (int a = 0; a < 4; a++) begin
      do_write(4'(a), 64'd0);
      check(nwr == 2 && got_fm == 0, "R7 learn fault", {56'd0, 8'(nwr), got_fm}, {56'd0, 8'd2, 8'd0});
      rd_check(4'(a), 64'd0, 8'd0);
    end
    do_write(4'd14, 64'd0);
    check(nwr == 2, "R11 oldest entry evicted", {64'd0, 8'(nwr)}, {64'd0, 8'd2});
    do_write(4'd1, 64'd0);
    check(nwr == 1 && last_flags == 8'h02, "R11 newer entry kept",
          {56'd0, 8'(nwr), last_flags}, {56'd0, 8'd1, 8'h02});

    // R6: uncorrectable partition
    do_write(4'd12, 64'd0);
    check(nwr == 2 && got_fm == 8'h08 && got_fl, "R6 two faults flagged",
          {55'd0, 8'(nwr), got_fm, got_fl}, {55'd0, 8'd2, 8'h08, 1'b1});
    rd_check(4'd12, 64'd0, 8'h08);

    // random phase
    for (int n = 0; n < 300; n++) begin
      int a;
      logic [7:0] ef;
      a = $urandom_range(0, 11);
      d = {$urandom, $urandom};
      ef = exp_fail(a, d);
      do_write(4'(a), d);
      check(got_fm == ef, "R6 random fail mask", {64'd0, got_fm}, {64'd0, ef});
      check(nwr == 1 || nwr == 2, "R4 write count", {64'd0, 8'(nwr)}, {64'd0, 8'd2});
      if (plain_ok(a, d))
        check(nwr == 1, "R3 no second write needed", {64'd0, 8'(nwr)}, {64'd0, 8'd1});
      rd_check(4'(a), d, ef);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule